// File: doc/BRIEF.md
# Event Log Ring Producer

This block is the hardware side of a circular event log kept in memory. Event records arrive on a valid/ready input, each carrying an error byte, an operation code and a fault address. The block writes each accepted record into the ring slot at its tail index through a single-cycle memory write port, then moves the tail on by one, wrapping at the configured ring size. Software consumes records from the head and reports its progress by writing the head index back.

A register port gives software a 64-bit status view, read as two 32-bit words, plus a cause word. The status view holds the head index, the tail index and an interrupt-pending flag. Every record written sets that flag and an event-log cause bit, which drives the interrupt output. Both are cleared by writing 1. When the ring is full the block holds its input ready low, so no record is dropped and no slot is overwritten.

Top module: `evlog_producer`

## Requirements
- R1: After reset, head and tail are 0, interrupt-pending is 0, the cause word reads 0, `irq` is 0 and `ring_empty` is 1.
- R2: A record accepted on an edge (`ev_valid` and `ev_ready` high) is written on the next cycle with `mem_wr_en` high for one cycle, `mem_wr_addr` = `cfg_base` + tail × `ENTRY_BYTES` (tail before the advance) and `mem_wr_data` = {fault, op, err}. The error byte is passed through unchanged: status in bits [6:0] and the status-write flag in bit 7. On the same edge the tail becomes (tail + 1) mod `cfg_size`.
- R3: The ring is full when (tail + 1) mod `cfg_size` equals head. While it is full, `ev_ready` is low, no memory write happens and the tail holds. The waiting record is accepted once software moves the head.
- R4: `ring_empty` is 1 exactly when head equals tail.
- R5: A write to register address 0 (status low word) loads head from `reg_wdata[IDX_W-1:0]`. Higher data bits are ignored.
- R6: Address 0 reads {16'b0, head}. Address 1 (status high word) reads the tail in bits [15:0] and the pending flag in bit 30, which is bit 62 of the 64-bit status. All other status bits read 0.
- R7: Every accepted record sets the pending flag and cause bit 5 (value 0x20) at address 2. `irq` is 1 exactly when cause bit 5 is set.
- R8: A write to address 1 with bit 30 set clears the pending flag. With bit 30 clear, the write has no effect. The tail is never changed by a register write.
- R9: A write to address 2 with bit 5 set clears cause bit 5, and `irq` with it.
- R10: When a clear of the pending flag or of the cause bit lands on the same edge as an accepted record, the flag or bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | IDX_W | Number of ring slots (at least 2), held stable outside reset |
| cfg_base | input | ADDR_W | Byte address of slot 0 |
| ev_valid | input | 1 | Event record offered |
| ev_ready | output | 1 | Ring has room and the record is taken |
| ev_err | input | 8 | Error byte: status [6:0], status-write flag [7] |
| ev_op | input | OP_W | Operation code |
| ev_fault | input | FAULT_W | Fault address |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the slot written |
| mem_wr_data | output | 8+OP_W+FAULT_W | Record {fault, op, err} |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status low, 1 status high, 2 cause |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ring_empty | output | 1 | Head equals tail |
| irq | output | 1 | Event-log interrupt |

## Verification
The bench uses the default parameters (16-bit indices, 32-byte entries, 8-bit operation code, 64-bit fault address). It drives `cfg_size` to 4 or 5 through the configuration input, so a handful of records is enough to fill the ring, hold a record under backpressure and wrap the tail back to slot 0. It checks slot addresses against base plus index times 32. It lines up record arrival with pending and cause clears on the same edge to cover the set-wins rule.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

  localparam int REG_STAT_LO = 0;
  localparam int REG_STAT_HI = 1;
  localparam int REG_CAUSE   = 2;
  localparam int PEND_BIT    = 30;  // bit 62 of the 64-bit status
  localparam int CAUSE_BIT   = 5;   // value 0x20

  // Index after t in a ring of sz slots.
  function automatic logic [31:0] ring_next(input logic [31:0] t, input logic [31:0] sz);
    logic [31:0] n;
    n = t + 32'd1;
    return (n >= sz) ? 32'd0 : n;
  endfunction

  // Byte address of slot idx.
  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [31:0] idx,
                                            input logic [31:0] ebytes);
    return base + idx * ebytes;
  endfunction

endpackage

// File: rtl/evlog_ring_ctrl.sv
module evlog_ring_ctrl #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_size,
  input  logic             ev_valid,
  input  logic             head_wr,
  input  logic [IDX_W-1:0] head_wdata,
  output logic             ev_ready,
  output logic             accept,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic             full,
  output logic             empty
);

  logic [IDX_W-1:0] tail_next;

  assign tail_next = IDX_W'(evlog_pkg::ring_next(32'(tail), 32'(cfg_size)));
  assign full      = (tail_next == head);
  assign empty     = (tail == head);
  assign ev_ready  = !full;
  assign accept    = ev_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail <= '0;
      head <= '0;
    end else begin
      if (accept)  tail <= tail_next;
      if (head_wr) head <= head_wdata;
    end
  end

  // R2: each accepted record moves the tail one slot with wrap
  assert_tail_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (32'(tail) == evlog_pkg::ring_next(32'($past(tail)), 32'($past(cfg_size)))));

  // R3, R8: nothing but an accepted record moves the tail
  assert_tail_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(tail));

endmodule

// File: rtl/evlog_mem_wr.sv
module evlog_mem_wr #(
  parameter int IDX_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int REC_W       = 80,
  parameter int ENTRY_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  tail,
  input  logic [REC_W-1:0]  record,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [REC_W-1:0]  mem_wr_data
);

  logic [ADDR_W-1:0] addr_now;

  assign addr_now = ADDR_W'(evlog_pkg::slot_addr(32'(cfg_base), 32'(tail), 32'(ENTRY_BYTES)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      mem_wr_en <= accept;
      if (accept) begin
        mem_wr_addr <= addr_now;
        mem_wr_data <= record;
      end
    end
  end

  // R2: a write strobe lasts one cycle per accepted record
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(accept));

endmodule

// File: rtl/evlog_regs.sv
module evlog_regs #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  output logic             head_wr,
  output logic [IDX_W-1:0] head_wdata,
  output logic             pending,
  output logic             cause_evl,
  output logic [31:0]      reg_rdata
);

  import evlog_pkg::*;

  logic pend_clr;
  logic cause_clr;
  logic unused_wdata;

  assign head_wr      = reg_wr && (reg_addr == 2'(REG_STAT_LO));
  assign head_wdata   = reg_wdata[IDX_W-1:0];
  assign pend_clr     = reg_wr && (reg_addr == 2'(REG_STAT_HI)) && reg_wdata[PEND_BIT];
  assign cause_clr    = reg_wr && (reg_addr == 2'(REG_CAUSE)) && reg_wdata[CAUSE_BIT];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      cause_evl <= 1'b0;
    end else begin
      // a new record wins over a clear on the same edge
      if (accept)        pending <= 1'b1;
      else if (pend_clr) pending <= 1'b0;
      if (accept)         cause_evl <= 1'b1;
      else if (cause_clr) cause_evl <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'(REG_STAT_LO): reg_rdata[IDX_W-1:0] = head;
      2'(REG_STAT_HI): begin
        reg_rdata[IDX_W-1:0] = tail;
        reg_rdata[PEND_BIT]  = pending;
      end
      2'(REG_CAUSE):   reg_rdata[CAUSE_BIT] = cause_evl;
      default:         reg_rdata = '0;
    endcase
  end

  // R7, R10: a record always leaves both flags set
  assert_flags_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pending && cause_evl));

  // R8: a clear with no record drops pending
  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !accept) |=> !pending);

  // R9: a clear with no record drops the cause bit
  assert_cause_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_clr && !accept) |=> !cause_evl);

endmodule

// File: rtl/evlog_producer.sv
module evlog_producer #(
  parameter int IDX_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int OP_W        = 8,
  parameter int FAULT_W     = 64,
  parameter int ENTRY_BYTES = 32,
  localparam int REC_W      = 8 + OP_W + FAULT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   cfg_size,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [7:0]         ev_err,
  input  logic [OP_W-1:0]    ev_op,
  input  logic [FAULT_W-1:0] ev_fault,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [REC_W-1:0]   mem_wr_data,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               ring_empty,
  output logic               irq
);

  // named internal events for the assertions
  logic             accept;
  logic             full;
  logic [IDX_W-1:0] tail;
  logic [IDX_W-1:0] head;
  logic             head_wr;
  logic [IDX_W-1:0] head_wdata;
  logic             pending;
  logic             cause_evl;
  logic [REC_W-1:0] record;

  assign record = {ev_fault, ev_op, ev_err};
  assign irq    = cause_evl;

  evlog_ring_ctrl #(.IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .ev_valid(ev_valid),
    .head_wr(head_wr), .head_wdata(head_wdata), .ev_ready(ev_ready),
    .accept(accept), .tail(tail), .head(head), .full(full), .empty(ring_empty)
  );

  evlog_mem_wr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .REC_W(REC_W),
                 .ENTRY_BYTES(ENTRY_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cfg_base(cfg_base),
    .tail(tail), .record(record), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  evlog_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .head(head), .tail(tail),
    .head_wr(head_wr), .head_wdata(head_wdata), .pending(pending),
    .cause_evl(cause_evl), .reg_rdata(reg_rdata)
  );

  // R3: an offer into a full ring produces no write
  assert_no_write_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && full) |=> !mem_wr_en);

  // R4: empty and full never coexist for a ring of two or more slots
  assert_empty_not_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_size > IDX_W'(1)) |-> !(ring_empty && full));

endmodule

// File: tb/sim_evlog_producer.sv
`timescale 1ns/1ps
module sim_evlog_producer;

  localparam int IDX_W = 16, ADDR_W = 32, OP_W = 8, FAULT_W = 64, EB = 32;
  localparam int REC_W = 8 + OP_W + FAULT_W;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IDX_W-1:0] cfg_size = 16'd4;
  logic [ADDR_W-1:0] cfg_base = BASE;
  logic ev_valid = 1'b0, ev_ready;
  logic [7:0] ev_err = '0;
  logic [OP_W-1:0] ev_op = '0;
  logic [FAULT_W-1:0] ev_fault = '0;
  logic mem_wr_en;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [REC_W-1:0] mem_wr_data;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ring_empty, irq;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  evlog_producer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_err(ev_err), .ev_op(ev_op),
    .ev_fault(ev_fault), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ring_empty(ring_empty), .irq(irq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [IDX_W-1:0] sz);
    @(negedge clk);
    rst_n = 1'b0; cfg_size = sz;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // offer one record; it is taken on the next edge (ready assumed high)
  task automatic push(input logic [7:0] e, input logic [7:0] op, input logic [63:0] f,
                      input int slot, input string req);
    @(negedge clk);
    ev_valid = 1'b1; ev_err = e; ev_op = op; ev_fault = f;
    @(negedge clk);
    ev_valid = 1'b0;
    chk({req, " wr_en"}, 128'(mem_wr_en), 128'(1));
    chk({req, " addr"}, 128'(mem_wr_addr), 128'(BASE + 32'(slot) * EB));
    chk({req, " data"}, 128'(mem_wr_data), 128'({f, op, e}));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    do_reset(16'd4);
    reg_read(2'd0, d); chk("R1 head", 128'(d), 0);
    reg_read(2'd1, d); chk("R1 tail/pend", 128'(d), 0);
    reg_read(2'd2, d); chk("R1 cause", 128'(d), 0);
    chk("R1 irq", 128'(irq), 0);
    chk("R1 empty", 128'(ring_empty), 1);
    chk("R1 ready", 128'(ev_ready), 1);
  endtask

  task automatic t_fill_wrap;
    logic [31:0] d;
    do_reset(16'd4);
    push(8'h85, 8'h11, 64'hDEAD_BEEF_0000_0001, 0, "R2 rec0");
    reg_read(2'd1, d); chk("R2 tail1", 128'(d[15:0]), 1);
    chk("R4 not empty", 128'(ring_empty), 0);
    push(8'h7F, 8'h22, 64'h0000_0000_1234_5678, 1, "R2 rec1");
    push(8'h00, 8'h33, 64'hFFFF_FFFF_FFFF_FFFF, 2, "R2 rec2");
    reg_read(2'd1, d); chk("R2 tail3", 128'(d[15:0]), 3);
    chk("R3 ready low when full", 128'(ev_ready), 0);
    // hold an offer against the full ring
    @(negedge clk);
    ev_valid = 1'b1; ev_err = 8'hC4; ev_op = 8'h44; ev_fault = 64'hABCD;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 no write while full", 128'(mem_wr_en), 0);
    end
    reg_read(2'd1, d); chk("R3 tail held", 128'(d[15:0]), 3);
    // software frees one slot: head=1, record then goes into slot 3
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R3 ready after head move", 128'(ev_ready), 1);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R3 held rec written", 128'(mem_wr_en), 1);
    chk("R3 held rec addr", 128'(mem_wr_addr), 128'(BASE + 32'd3 * EB));
    chk("R3 held rec data", 128'(mem_wr_data), 128'({64'hABCD, 8'h44, 8'hC4}));
    reg_read(2'd1, d); chk("R2 tail wraps to 0", 128'(d[15:0]), 0);
    chk("R3 full again", 128'(ev_ready), 0);
  endtask

  task automatic t_empty_head;
    logic [31:0] d;
    do_reset(16'd5);
    push(8'h01, 8'h01, 64'h1, 0, "R2 size5 rec0");
    push(8'h02, 8'h02, 64'h2, 1, "R2 size5 rec1");
    chk("R4 not empty", 128'(ring_empty), 0);
    reg_write(2'd0, 32'hABCD_0002);
    reg_read(2'd0, d); chk("R5 R6 head low bits only", 128'(d), 2);
    chk("R4 empty when head==tail", 128'(ring_empty), 1);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    do_reset(16'd4);
    push(8'h10, 8'h55, 64'h77, 0, "R7 rec");
    reg_read(2'd1, d); chk("R6 R7 high word", 128'(d), 128'(32'h4000_0001));
    reg_read(2'd2, d); chk("R7 cause", 128'(d), 128'(32'h20));
    chk("R7 irq", 128'(irq), 1);
    reg_write(2'd1, 32'h0000_FFFF);
    reg_read(2'd1, d); chk("R8 no clear, tail kept", 128'(d), 128'(32'h4000_0001));
    reg_write(2'd1, 32'h4000_0003);
    reg_read(2'd1, d); chk("R8 pending cleared", 128'(d), 128'(32'h0000_0001));
    chk("R8 irq stays until cause clear", 128'(irq), 1);
    reg_write(2'd2, 32'h0000_0001);
    chk("R9 wrong bit no clear", 128'(irq), 1);
    reg_write(2'd2, 32'h0000_0020);
    reg_read(2'd2, d); chk("R9 cause cleared", 128'(d), 0);
    chk("R9 irq low", 128'(irq), 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    do_reset(16'd4);
    push(8'h01, 8'h01, 64'h1, 0, "R10 first");
    @(negedge clk);
    ev_valid = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h4000_0000;
    @(negedge clk);
    ev_valid = 1'b0; reg_wr = 1'b0;
    reg_read(2'd1, d); chk("R10 pending survives clear", 128'(d), 128'(32'h4000_0002));
    @(negedge clk);
    ev_valid = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h20;
    @(negedge clk);
    ev_valid = 1'b0; reg_wr = 1'b0;
    chk("R10 irq survives clear", 128'(irq), 1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_fill_wrap;
    t_empty_head;
    t_regs;
    t_collide;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule